// File: doc/BRIEF.md
# Prioritized Memory Chip-Select Decoder

This block turns a 16-bit processor address into exactly one select line. The targets are four main flash sectors, four secondary sectors (EEPROM or boot flash), a 2K x 8 SRAM and one I/O window. Each target claims an address window through run-time registers. A window is a base, a limit and an enable. The SRAM has two such windows, and a hit in either one selects it.

Windows may overlap when they belong to different priority tiers. The SRAM and I/O windows form the top tier. The secondary sectors form the middle tier, and the main flash sectors form the bottom tier. When several tiers hit, only the highest tier drives a select. Overlap inside one tier is a configuration mistake. So is a window that is larger than its physical sector. In both cases the decoder raises a registered error flag.

The select outputs are combinational from the address and are gated by a valid strobe. The error flag is computed from the configuration registers and registered one more time, so it follows a configuration write one cycle later.

Top module: `cs_decoder`

## Requirements
- R1: All select outputs are low while addr_valid is low, and while no enabled window contains the address.
- R2: At most one of main_sel, sec_sel, sram_sel and io_sel is high in any cycle, for any configuration.
- R3: A hit in a top-tier window wins over every other tier. The SRAM is selected when either of its two windows (window 8 or window 9) contains the address.
- R4: A secondary-sector hit wins over any main-sector hit.
- R5: Under an illegal same-tier overlap, the lowest-numbered sector in that tier wins. When the SRAM and the I/O window both hit, the SRAM wins.
- R6: An enabled window covers the addresses from base to limit, both included. A window that is disabled, or whose base is greater than its limit, covers nothing.
- R7: The configuration word address is cfg_addr[5:2] = window number and cfg_addr[1:0] = field. Windows 0-3 are main sectors 0-3, windows 4-7 are secondary sectors 0-3, windows 8-9 are the two SRAM windows and window 10 is the I/O window. Field 0 is the base, field 1 is the limit, and field 2 is the enable, taken from cfg_wdata[0]. After reset every window is disabled, so no select is high and cfg_error is low.
- R8: cfg_error is high when two enabled, non-empty windows of the same tier overlap and lead to different targets. The SRAM window against the I/O window counts as such a pair. The two SRAM windows overlapping each other does not.
- R9: cfg_error is high when an enabled window is larger than its sector size. The limits are 16384 bytes for a main sector, 8192 bytes for a secondary sector and 2048 bytes for an SRAM window. The I/O window has no size limit.
- R10: cfg_error is registered. It still shows the old value in the cycle after the clock edge that writes a configuration register. It shows the new value from one clock later, and it drops once the configuration is legal again.
- R11: Take main sector 0 at 0x8000-0xBFFF, secondary sector 0 at 0x8000-0x9FFF and SRAM window 0 at 0x8000-0x87FF. Then 0x8000-0x87FF selects the SRAM, 0x8800-0x9FFF selects secondary sector 0 and 0xA000-0xBFFF selects main sector 0, with no error. Adding main sector 1 anywhere inside 0x8000-0xBFFF raises cfg_error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid | input | 1 | Qualifies addr for decoding |
| addr | input | 16 | Processor address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Window number [5:2] and field [1:0] |
| cfg_wdata | input | 16 | Configuration write data |
| main_sel | output | 4 | One-hot main flash sector select |
| sec_sel | output | 4 | One-hot secondary sector select |
| sram_sel | output | 1 | SRAM select, active high |
| io_sel | output | 1 | I/O window select |
| cfg_error | output | 1 | Registered overlap or size violation flag |

## Verification
Two functions can act in the same cycle. One is the combinational address decode. The other is the registered rule check, which still works on the configuration from before a write. The bench writes a register that creates a same-tier overlap and probes an address inside both overlapping sectors in the cycles right after the write. It then judges that the select already follows the new windows, lowest sector first, while cfg_error changes one cycle later. Random legal configurations are also compared against a reference model at random addresses and at every window edge, and every same-tier pair is forced to overlap to prove that the flag rises.

// File: rtl/csdec_pkg.sv
package csdec_pkg;

    localparam int ADDR_W    = 16;
    localparam int N_MAIN    = 4;
    localparam int N_SEC     = 4;
    localparam int N_SRAM_T  = 2;
    localparam int N_IO      = 1;
    localparam int N_WIN     = N_MAIN + N_SEC + N_SRAM_T + N_IO;
    localparam int WIN_IDX_W = $clog2(N_WIN);
    localparam int FLD_W     = 2;
    localparam int CFG_AW    = WIN_IDX_W + FLD_W;

    localparam int MAIN_IDX0 = 0;
    localparam int SEC_IDX0  = MAIN_IDX0 + N_MAIN;
    localparam int SRAM_IDX0 = SEC_IDX0 + N_SEC;
    localparam int IO_IDX0   = SRAM_IDX0 + N_SRAM_T;

    localparam int MAIN_SECT_BYTES = 16384;
    localparam int SEC_SECT_BYTES  = 8192;
    localparam int SRAM_BYTES      = 2048;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [ADDR_W:0]   span_t;

    typedef enum logic [FLD_W-1:0] {
        FLD_BASE  = 2'd0,
        FLD_LIMIT = 2'd1,
        FLD_EN    = 2'd2
    } fld_e;

    typedef struct packed {
        logic  en;
        addr_t base;
        addr_t limit;
    } win_t;

    // tier number: 1 is the highest priority
    function automatic int win_tier(int idx);
        if (idx >= SRAM_IDX0) return 1;
        if (idx >= SEC_IDX0)  return 2;
        return 3;
    endfunction

    // windows that drive the same select share a target number
    function automatic int win_target(int idx);
        if (idx >= SRAM_IDX0 && idx < IO_IDX0) return SRAM_IDX0;
        return idx;
    endfunction

    // same tier, different targets: overlap is forbidden
    function automatic bit pair_checked(int i, int j);
        return (i < j) && (win_tier(i) == win_tier(j)) &&
               (win_target(i) != win_target(j));
    endfunction

    // size limit in bytes, 0 means unlimited
    function automatic int size_cap(int idx);
        if (idx >= IO_IDX0)   return 0;
        if (idx >= SRAM_IDX0) return SRAM_BYTES;
        if (idx >= SEC_IDX0)  return SEC_SECT_BYTES;
        return MAIN_SECT_BYTES;
    endfunction

    function automatic logic win_live(win_t w);
        return w.en && (w.base <= w.limit);
    endfunction

    function automatic span_t win_span(win_t w);
        return {1'b0, w.limit} - {1'b0, w.base} + span_t'(1);
    endfunction

    function automatic logic win_hit(win_t w, addr_t a);
        return win_live(w) && (a >= w.base) && (a <= w.limit);
    endfunction

    function automatic logic win_overlap(win_t a, win_t b);
        return win_live(a) && win_live(b) &&
               (a.base <= b.limit) && (b.base <= a.limit);
    endfunction

endpackage

// File: rtl/csdec_cfg_regs.sv
module csdec_cfg_regs
    import csdec_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [CFG_AW-1:0]        cfg_addr,
    input  addr_t                    cfg_wdata,
    output win_t [N_WIN-1:0]         wins
);

    logic [WIN_IDX_W-1:0] wr_idx;
    fld_e                 wr_fld;

    assign wr_idx = cfg_addr[CFG_AW-1:FLD_W];
    assign wr_fld = fld_e'(cfg_addr[FLD_W-1:0]);

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                wins[g] <= '0;
            end else if (cfg_we && wr_idx == WIN_IDX_W'(g)) begin
                case (wr_fld)
                    FLD_BASE:  wins[g].base  <= cfg_wdata;
                    FLD_LIMIT: wins[g].limit <= cfg_wdata;
                    FLD_EN:    wins[g].en    <= cfg_wdata[0];
                    default:   ;
                endcase
            end
        end
    end

endmodule

// File: rtl/csdec_win_match.sv
module csdec_win_match
    import csdec_pkg::*;
(
    input  logic              addr_valid,
    input  addr_t             addr,
    input  win_t [N_WIN-1:0]  wins,
    output logic [N_WIN-1:0]  hit
);

    for (genvar g = 0; g < N_WIN; g++) begin : g_cmp
        assign hit[g] = addr_valid && win_hit(wins[g], addr);
    end

endmodule

// File: rtl/csdec_prio.sv
module csdec_prio
    import csdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_WIN-1:0]  hit,
    output logic [N_MAIN-1:0] main_sel,
    output logic [N_SEC-1:0]  sec_sel,
    output logic              sram_sel,
    output logic              io_sel
);

    logic [N_MAIN-1:0]   main_hit, main_first;
    logic [N_SEC-1:0]    sec_hit, sec_first;
    logic [N_SRAM_T-1:0] sram_hit;
    logic [N_IO-1:0]     io_hit;
    logic                tier1_any, tier2_any;

    assign main_hit = hit[MAIN_IDX0 +: N_MAIN];
    assign sec_hit  = hit[SEC_IDX0  +: N_SEC];
    assign sram_hit = hit[SRAM_IDX0 +: N_SRAM_T];
    assign io_hit   = hit[IO_IDX0   +: N_IO];

    // isolate the lowest set bit inside a tier
    assign main_first = main_hit & (~main_hit + N_MAIN'(1));
    assign sec_first  = sec_hit  & (~sec_hit  + N_SEC'(1));

    assign tier1_any = (|sram_hit) || (|io_hit);
    assign tier2_any = |sec_hit;

    always_comb begin
        sram_sel = |sram_hit;
        io_sel   = (|io_hit) && !sram_sel;
        sec_sel  = tier1_any ? '0 : sec_first;
        main_sel = (tier1_any || tier2_any) ? '0 : main_first;
    end

    p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({main_sel, sec_sel, sram_sel, io_sel}));

    p_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !(|hit) |-> ({main_sel, sec_sel, sram_sel, io_sel} == '0));

    p_tier1_wins_r3: assert property (@(posedge clk) disable iff (rst)
        tier1_any |-> (main_sel == '0 && sec_sel == '0 && (sram_sel || io_sel)));

    p_tier2_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (|main_sel) |-> !(|sec_hit));

endmodule

// File: rtl/csdec_rule_check.sv
module csdec_rule_check
    import csdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  win_t [N_WIN-1:0]  wins,
    output logic              cfg_error
);

    logic [N_WIN*N_WIN-1:0] pair_bad;
    logic [N_WIN-1:0]       size_bad;
    logic                   err_next;

    for (genvar i = 0; i < N_WIN; i++) begin : g_row
        for (genvar j = 0; j < N_WIN; j++) begin : g_col
            if (pair_checked(i, j)) begin : g_chk
                assign pair_bad[i*N_WIN+j] = win_overlap(wins[i], wins[j]);
            end else begin : g_skip
                assign pair_bad[i*N_WIN+j] = 1'b0;
            end
        end
    end

    for (genvar g = 0; g < N_WIN; g++) begin : g_size
        if (size_cap(g) != 0) begin : g_cap
            localparam span_t CAP = span_t'(size_cap(g));
            assign size_bad[g] = win_live(wins[g]) && (win_span(wins[g]) > CAP);
        end else begin : g_free
            assign size_bad[g] = 1'b0;
        end
    end

    assign err_next = (|pair_bad) || (|size_bad);

    always_ff @(posedge clk) begin
        if (rst) cfg_error <= 1'b0;
        else     cfg_error <= err_next;
    end

    // without writes the flag cannot move
    p_err_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(cfg_we) && !$past(cfg_we, 2)) |-> $stable(cfg_error));

endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
    import csdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_valid,
    input  logic [15:0]       addr,
    input  logic              cfg_we,
    input  logic [5:0]        cfg_addr,
    input  logic [15:0]       cfg_wdata,
    output logic [3:0]        main_sel,
    output logic [3:0]        sec_sel,
    output logic              sram_sel,
    output logic              io_sel,
    output logic              cfg_error
);

    win_t [N_WIN-1:0] wins;
    logic [N_WIN-1:0] hit;

    csdec_cfg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .wins      (wins)
    );

    csdec_win_match u_match (
        .addr_valid (addr_valid),
        .addr       (addr),
        .wins       (wins),
        .hit        (hit)
    );

    csdec_prio u_prio (
        .clk      (clk),
        .rst      (rst),
        .hit      (hit),
        .main_sel (main_sel),
        .sec_sel  (sec_sel),
        .sram_sel (sram_sel),
        .io_sel   (io_sel)
    );

    csdec_rule_check u_rules (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .wins      (wins),
        .cfg_error (cfg_error)
    );

    p_no_sel_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !addr_valid |-> ({main_sel, sec_sel, sram_sel, io_sel} == '0));

endmodule

// File: tb/test_cs_decoder.sv
`timescale 1ns/1ps
module test_cs_decoder;

    localparam real CLK_NS = 4.0;
    localparam int  NW = 11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_valid = 1'b0;
    logic [15:0] addr = '0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [3:0]  main_sel, sec_sel;
    logic        sram_sel, io_sel, cfg_error;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [15:0] mb [NW];
    logic [15:0] ml [NW];
    logic        me [NW];

    logic [9:0]  q_exp [$];
    string       q_tag [$];

    always #(CLK_NS/2) clk = ~clk;

    cs_decoder i_cs_decoder (
        .clk(clk), .rst(rst), .addr_valid(addr_valid), .addr(addr),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .main_sel(main_sel), .sec_sel(sec_sel), .sram_sel(sram_sel),
        .io_sel(io_sel), .cfg_error(cfg_error)
    );

    function automatic int tier_of(int k);
        if (k >= 8) return 1;
        if (k >= 4) return 2;
        return 3;
    endfunction

    function automatic int cap_of(int k);
        if (k == 10) return 0;
        if (k >= 8)  return 2048;
        if (k >= 4)  return 8192;
        return 16384;
    endfunction

    function automatic bit live(int k);
        return me[k] && (mb[k] <= ml[k]);
    endfunction

    // bit layout: [3:0] main, [7:4] secondary, [8] sram, [9] io
    function automatic logic [9:0] ref_sel(logic v, logic [15:0] a);
        logic [9:0] r = '0;
        bit h [NW];
        if (!v) return r;
        for (int k = 0; k < NW; k++) h[k] = live(k) && mb[k] <= a && a <= ml[k];
        if (h[8] || h[9]) r[8] = 1'b1;
        else if (h[10]) r[9] = 1'b1;
        else begin
            for (int k = 4; k < 8; k++) if (h[k] && r == '0) r[k] = 1'b1;
            for (int k = 0; k < 4; k++) if (h[k] && r == '0) r[k] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic ref_err();
        for (int k = 0; k < NW; k++)
            if (live(k) && cap_of(k) != 0 && (int'(ml[k]) - int'(mb[k]) + 1) > cap_of(k))
                return 1'b1;
        for (int i = 0; i < NW; i++)
            for (int j = i + 1; j < NW; j++)
                if (tier_of(i) == tier_of(j) && !(i == 8 && j == 9) && live(i) && live(j)
                    && mb[i] <= ml[j] && mb[j] <= ml[i])
                    return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: apply address and push the expected select vector
    task automatic probe(logic v, logic [15:0] a, string tag);
        @(negedge clk);
        addr_valid = v;
        addr = a;
        q_exp.push_back(ref_sel(v, a));
        q_tag.push_back(tag);
    endtask

    // monitor: pop and compare once the inputs have settled
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_exp.size() > 0) begin
                logic [9:0] e;
                string t;
                logic [9:0] act;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                act = {io_sel, sram_sel, sec_sel, main_sel};
                check(act == e, t, 16'(act), 16'(e));
            end
        end
    endtask_dummy: begin end
    end

    task automatic drain();
        while (q_exp.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wcfg(int idx, int fld, logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = 6'((idx << 2) | fld);
        cfg_wdata = d;
        if (fld == 0) mb[idx] = d;
        else if (fld == 1) ml[idx] = d;
        else if (fld == 2) me[idx] = d[0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_win(int idx, int b, int l, bit en);
        wcfg(idx, 2, 16'd0);
        wcfg(idx, 0, 16'(b));
        wcfg(idx, 1, 16'(l));
        wcfg(idx, 2, 16'(en));
    endtask

    task automatic clear_all();
        for (int k = 0; k < NW; k++) if (me[k]) wcfg(k, 2, 16'd0);
    endtask

    task automatic chk_err(string tag);
        repeat (2) @(negedge clk);
        check(cfg_error == ref_err(), tag, 16'(cfg_error), 16'(ref_err()));
    endtask

    task automatic rand_cfg();
        int s0, s1, s2, b;
        for (int k = 0; k < 4; k++) begin
            b = k * 16384 + int'($urandom % 8192);
            set_win(k, b, b + int'($urandom % 8192), ($urandom % 4) != 0);
        end
        for (int k = 0; k < 4; k++) begin
            b = (2 * k + int'($urandom % 2)) * 8192 + int'($urandom % 4096);
            set_win(4 + k, b, b + int'($urandom % 4096), ($urandom % 4) != 0);
        end
        s0 = int'($urandom % 8);
        s1 = (s0 + 1 + int'($urandom % 3)) % 8;
        s2 = (s0 + 4 + int'($urandom % 3)) % 8;
        b = s0 * 8192 + int'($urandom % 4096);
        set_win(8, b, b + int'($urandom % 2048), ($urandom % 3) != 0);
        b = s1 * 8192 + int'($urandom % 4096);
        set_win(9, b, b + int'($urandom % 2048), ($urandom % 3) != 0);
        b = s2 * 8192 + int'($urandom % 4096);
        set_win(10, b, b + int'($urandom % 2048), ($urandom % 3) != 0);
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NW; k++) begin mb[k] = '0; ml[k] = '0; me[k] = 1'b0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R7: reset state
        check(cfg_error == 1'b0, "R7 error low after reset", 16'(cfg_error), 16'd0);
        probe(1'b1, 16'h0000, "R7 no select after reset");
        probe(1'b1, 16'hFFFF, "R7 no select after reset");
        drain();

        // R11: overlapping scenario across tiers
        set_win(0, 'h8000, 'hBFFF, 1'b1);
        set_win(4, 'h8000, 'h9FFF, 1'b1);
        set_win(8, 'h8000, 'h87FF, 1'b1);
        chk_err("R11 scenario legal");
        probe(1'b1, 16'h8000, "R11 R3 sram low edge");
        probe(1'b1, 16'h87FF, "R11 R3 sram high edge");
        probe(1'b1, 16'h8800, "R11 R4 secondary low edge");
        probe(1'b1, 16'h9FFF, "R11 R4 secondary high edge");
        probe(1'b1, 16'hA000, "R11 main low edge");
        probe(1'b1, 16'hBFFF, "R11 main high edge");
        probe(1'b1, 16'hC000, "R11 R1 above windows");
        probe(1'b1, 16'h7FFF, "R11 R1 below windows");
        probe(1'b0, 16'h8000, "R1 valid low");
        drain();

        // R10 and R5: error lags by a cycle while decode follows at once
        wcfg(1, 0, 16'hA000);
        wcfg(1, 1, 16'hA0FF);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'((1 << 2) | 2); cfg_wdata = 16'd1; me[1] = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        addr_valid = 1'b1; addr = 16'hA080;
        q_exp.push_back(ref_sel(1'b1, 16'hA080));
        q_tag.push_back("R5 lowest main sector under overlap");
        check(cfg_error == 1'b0, "R10 old value one cycle after write", 16'(cfg_error), 16'd0);
        @(negedge clk);
        check(cfg_error == 1'b1, "R10 R11 second main sector flagged", 16'(cfg_error), 16'd1);
        drain();
        wcfg(1, 2, 16'd0);
        chk_err("R10 error clears when corrected");

        // R6: inverted and disabled windows
        set_win(2, 'h5000, 'h4000, 1'b1);
        probe(1'b1, 16'h4800, "R6 base above limit covers nothing");
        probe(1'b1, 16'h5000, "R6 base above limit covers nothing");
        drain();
        chk_err("R6 inverted window not an error");
        clear_all();
        probe(1'b1, 16'h8000, "R6 disabled windows");
        drain();

        // R8: every forbidden same-tier pair
        for (int i = 0; i < 4; i++)
            for (int j = i + 1; j < 4; j++) begin
                set_win(i, 'h1000, 'h1FFF, 1'b1);
                set_win(j, 'h1800, 'h27FF, 1'b1);
                chk_err("R8 main pair overlap");
                probe(1'b1, 16'h1900, "R5 main pair lowest wins");
                drain();
                clear_all();
                chk_err("R8 main pair cleared");
            end
        for (int i = 4; i < 8; i++)
            for (int j = i + 1; j < 8; j++) begin
                set_win(i, 'h3000, 'h3FFF, 1'b1);
                set_win(j, 'h3FFF, 'h4FFF, 1'b1);
                chk_err("R8 secondary pair overlap");
                probe(1'b1, 16'h3FFF, "R5 secondary pair lowest wins");
                drain();
                clear_all();
            end
        set_win(8, 'h6000, 'h63FF, 1'b1);
        set_win(10, 'h6200, 'h6FFF, 1'b1);
        chk_err("R8 sram window 0 against io");
        probe(1'b1, 16'h6300, "R5 sram beats io");
        probe(1'b1, 16'h6400, "R3 io alone");
        drain();
        clear_all();
        set_win(9, 'h6000, 'h63FF, 1'b1);
        set_win(10, 'h63FF, 'h6FFF, 1'b1);
        chk_err("R8 sram window 1 against io");
        clear_all();
        set_win(8, 'h6000, 'h67FF, 1'b1);
        set_win(9, 'h6400, 'h6BFF, 1'b1);
        chk_err("R8 sram windows may overlap each other");
        probe(1'b1, 16'h6A00, "R3 second sram window selects sram");
        drain();
        clear_all();

        // R9: size limits at and beyond the boundary
        set_win(0, 'h0000, 'h3FFF, 1'b1);
        chk_err("R9 main at full size");
        set_win(0, 'h0000, 'h4000, 1'b1);
        chk_err("R9 main one byte too large");
        clear_all();
        set_win(5, 'h2000, 'h3FFF, 1'b1);
        chk_err("R9 secondary at full size");
        set_win(5, 'h2000, 'h4000, 1'b1);
        chk_err("R9 secondary one byte too large");
        clear_all();
        set_win(9, 'h0100, 'h08FF, 1'b1);
        chk_err("R9 sram at full size");
        set_win(9, 'h0100, 'h0900, 1'b1);
        chk_err("R9 sram one byte too large");
        clear_all();
        set_win(10, 'h0000, 'hFFFF, 1'b1);
        chk_err("R9 io has no size limit");
        clear_all();

        // R2 R3 R4: random legal configurations against the model
        for (int n = 0; n < 15; n++) begin
            rand_cfg();
            chk_err("R8 R9 random legal config has no error");
            for (int k = 0; k < NW; k++) begin
                probe(1'b1, mb[k], "R2 R6 window base");
                probe(1'b1, ml[k], "R2 R6 window limit");
            end
            for (int t = 0; t < 60; t++)
                probe(($urandom % 8) != 0, 16'($urandom), "R2 R3 R4 random address");
            drain();
            clear_all();
        end

        drain();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule